// File: doc/BRIEF.md
# Qualified GPIO Timestamp Event Interrupt Logic

This block watches a small group of general-purpose input pins that serve as sources for timestamp capture. Each pin has its own polarity bit that picks the active level. A pin only produces an event after it has held its active level for longer than a minimum pulse width, counted in clock cycles. Shorter glitches are dropped. A qualified event emits a one-cycle capture strobe, which an external timestamp latch samples. The same event sets a per-pin capture status bit.

A shared timer status bit is set by a timer-match pulse. When the pins are allowed to clear it, any qualified pin event clears that bit. Software clears every status bit through write-one-to-clear strobes. A registered interrupt output combines each status bit with its enable.

The timestamp counter and the register address decoding sit outside the block. The block receives already-decoded control bits and clear strobes.

Top module: `gpio_ts_event_irq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `cap_sts`, `tmr_sts`, `cap_strobe` and `irq` are all 0.
- R2: A `pin_pol` bit of 1 makes high the active level for that pin, and a bit of 0 makes low the active level.
- R3: A pulse at the active level that lasts MIN_CYC sampled cycles or fewer produces no event. MIN_CYC is MIN_WIDTH_PS/CLK_PERIOD_PS rounded up, which is 10 by default. A pulse of MIN_CYC+1 cycles or more produces an event. The strobe rises on the (MIN_CYC+3)th clock edge after the pin first goes active.
- R4: Each active stretch gives exactly one `cap_strobe` pulse, one cycle wide, however long the pin stays active. A second event requires the pin to go inactive and then active again.
- R5: When a pin's `pin_input_mode` bit is 0, that pin gives no strobe and its status bit does not change.
- R6: On the edge after a strobe, `cap_sts` is set. A `sw_clr_cap` bit of 1 clears it on the next edge. If a set and a clear fall in the same cycle, the set wins.
- R7: A `tmr_match` pulse sets `tmr_sts` on the next edge, and `sw_clr_tmr` clears it.
- R8: When `tmr_clr_en` is 1, a strobe on any pin clears `tmr_sts` on the next edge. When `tmr_clr_en` is 0, `tmr_sts` is left unchanged.
- R9: If `tmr_match` and a GPIO-driven clear fall in the same cycle, `tmr_sts` stays set.
- R10: `irq` is a register. It goes to 1 one cycle after any `cap_sts` bit that is enabled by `cap_en`, or after `tmr_sts` when `tmr_irq_en` is 1. Otherwise it goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous capture pins |
| pin_input_mode | input | NUM_PINS | 1 = pin is used as a capture input |
| pin_pol | input | NUM_PINS | 1 = active high, 0 = active low |
| cap_en | input | NUM_PINS | Interrupt enable per capture status bit |
| tmr_clr_en | input | 1 | Allows pin events to clear the timer status |
| tmr_irq_en | input | 1 | Interrupt enable for the timer status |
| tmr_match | input | 1 | Timer-match pulse that sets the timer status |
| sw_clr_cap | input | NUM_PINS | Write-one-to-clear strobes for the capture status |
| sw_clr_tmr | input | 1 | Write-one-to-clear strobe for the timer status |
| cap_sts | output | NUM_PINS | Capture status bits |
| tmr_sts | output | 1 | Timer status bit |
| cap_strobe | output | NUM_PINS | One-cycle capture strobe for the timestamp latch |
| irq | output | 1 | Registered combined interrupt |

## Verification
Two pairs of functions can land in the same cycle. A capture strobe can meet a software clear of that pin's status. A GPIO-driven timer clear can meet a timer-match set. The bench waits for the strobe at a falling clock edge and, at that same falling edge, raises `sw_clr_cap` or `tmr_match`. Both requests then reach the status register on the following rising edge. Each case passes only if the status bit reads 1 afterwards, since the set has priority.

// File: rtl/gts_pkg.sv
// Package: shared helpers for the qualified GPIO timestamp event logic.
// Assumes widths and periods are given as positive integers in picoseconds.
package gts_pkg;

    // Rounds a minimum pulse width up to a whole number of clock cycles.
    function automatic int unsigned width_to_cycles(input int unsigned width_ps,
                                                    input int unsigned period_ps);
        return (width_ps + period_ps - 1) / period_ps;
    endfunction

    // Polarity encoding for one pin's active level.
    typedef enum logic {
        ACT_LOW  = 1'b0,
        ACT_HIGH = 1'b1
    } act_lvl_e;

endpackage

// File: rtl/gts_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pins.
// Assumes every bit is an independent level signal and that no bus coherence is needed.
module gts_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two register stages that settle metastability on the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/gts_width_qual.sv
// Module: qualifies one synchronised pin by the time it spends at its active level.
// It counts active cycles, saturates one above the limit, and emits one registered
// event when the count first exceeds MIN_CYC. Going inactive, or leaving input
// mode, resets the count. Assumes the pin level is already synchronous.
module gts_width_qual
    import gts_pkg::*;
#(
    parameter int unsigned MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic pol,
    input  logic arm,
    output logic evt
);

    localparam int unsigned CW = $clog2(MIN_CYC + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);
    localparam logic [CW-1:0] SAT   = CW'(MIN_CYC + 1);

    logic          active;
    logic [CW-1:0] cnt_q;
    logic          evt_q;

    // The pin counts as active only in input mode and at the level pol selects.
    assign active = arm && (lvl == ((pol == ACT_HIGH) ? 1'b1 : 1'b0));

    // Active-level cycle counter. It saturates so each stretch matches LIMIT once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One-cycle event in the cycle where the active stretch passes the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= active && (cnt_q == LIMIT);
        end
    end

    assign evt = evt_q;

endmodule

// File: rtl/gts_sts_bit.sv
// Module: one status flag with a hardware set and a write-one-to-clear.
// A set and a clear in the same cycle leave the flag set.
module gts_sts_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    logic q_r;

    // Set has priority over clear; otherwise the flag holds its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else begin
            q_r <= set | (q_r & ~clr);
        end
    end

    assign q = q_r;

endmodule

// File: rtl/gpio_ts_event_irq.sv
// Module: top of the qualified GPIO timestamp event interrupt logic.
// Each pin is synchronised, then qualified by pulse width. The result drives a
// capture strobe and a capture status bit. A shared timer status is set by
// tmr_match and can be cleared by pin events. irq is registered.
// Assumes register decode and timestamp latching happen outside the block.
module gpio_ts_event_irq
    import gts_pkg::*;
#(
    parameter int unsigned NUM_PINS      = 2,
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned MIN_WIDTH_PS  = 40000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_input_mode,
    input  logic [NUM_PINS-1:0] pin_pol,
    input  logic [NUM_PINS-1:0] cap_en,
    input  logic                tmr_clr_en,
    input  logic                tmr_irq_en,
    input  logic                tmr_match,
    input  logic [NUM_PINS-1:0] sw_clr_cap,
    input  logic                sw_clr_tmr,
    output logic [NUM_PINS-1:0] cap_sts,
    output logic                tmr_sts,
    output logic [NUM_PINS-1:0] cap_strobe,
    output logic                irq
);

    localparam int unsigned MIN_CYC = width_to_cycles(MIN_WIDTH_PS, CLK_PERIOD_PS);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] evt;
    logic                gpio_tmr_clr;
    logic                irq_q;

    gts_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // One width qualifier and one capture status flag for each pin.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        gts_width_qual #(.MIN_CYC(MIN_CYC)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (pin_sync[g]),
            .pol   (pin_pol[g]),
            .arm   (pin_input_mode[g]),
            .evt   (evt[g])
        );

        gts_sts_bit u_cap_sts (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (evt[g]),
            .clr   (sw_clr_cap[g]),
            .q     (cap_sts[g])
        );
    end

    // A qualified event on any pin may clear the timer status.
    assign gpio_tmr_clr = tmr_clr_en & (|evt);

    gts_sts_bit u_tmr_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (tmr_match),
        .clr   (sw_clr_tmr | gpio_tmr_clr),
        .q     (tmr_sts)
    );

    // Registered OR of every status bit gated by its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (|(cap_sts & cap_en)) | (tmr_sts & tmr_irq_en);
        end
    end

    assign cap_strobe = evt;
    assign irq        = irq_q;

endmodule

// File: rtl/gts_checker.sv
// Module: assertion checker bound to gpio_ts_event_irq. It watches only ports.
module gts_checker #(
    parameter int unsigned NUM_PINS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_input_mode,
    input logic [NUM_PINS-1:0] cap_en,
    input logic                tmr_clr_en,
    input logic                tmr_irq_en,
    input logic                tmr_match,
    input logic [NUM_PINS-1:0] sw_clr_cap,
    input logic                sw_clr_tmr,
    input logic [NUM_PINS-1:0] cap_sts,
    input logic                tmr_sts,
    input logic [NUM_PINS-1:0] cap_strobe,
    input logic                irq
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        // R4
        strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_strobe[g] |=> !cap_strobe[g]);
        // R5
        idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_input_mode[g] |=> !cap_strobe[g]);
        // R6
        cap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_strobe[g] |=> cap_sts[g]);
        // R6
        cap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr_cap[g] && !cap_strobe[g]) |=> !cap_sts[g]);
    end

    // R7
    tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_match |=> tmr_sts);
    // R7
    tmr_swclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_tmr && !tmr_match) |=> !tmr_sts);
    // R8
    tmr_gpioclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cap_strobe) && tmr_clr_en && !tmr_match) |=> !tmr_sts);
    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(cap_sts & cap_en)) || (tmr_sts && tmr_irq_en)) |=> irq);
    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(cap_sts & cap_en)) && !(tmr_sts && tmr_irq_en)) |=> !irq);

endmodule

bind gpio_ts_event_irq gts_checker #(.NUM_PINS(NUM_PINS)) u_gts_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_input_mode (pin_input_mode),
    .cap_en         (cap_en),
    .tmr_clr_en     (tmr_clr_en),
    .tmr_irq_en     (tmr_irq_en),
    .tmr_match      (tmr_match),
    .sw_clr_cap     (sw_clr_cap),
    .sw_clr_tmr     (sw_clr_tmr),
    .cap_sts        (cap_sts),
    .tmr_sts        (tmr_sts),
    .cap_strobe     (cap_strobe),
    .irq            (irq)
);

// File: tb/gpio_ts_event_irq_bench.sv
`timescale 1ns/1ps
module gpio_ts_event_irq_bench;

    localparam int MIN_CYC = 10;   // 40000 ps / 4000 ps
    localparam int NV      = 8;

    typedef struct packed {
        logic       pin;
        logic       pol;
        logic [7:0] width;
        logic       expect_evt;
    } vec_t;

    // Stimulus table: pin, polarity, active width in cycles, expected event count.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'd10, 1'b0},   // R3 exactly at limit: ignored
        '{1'b0, 1'b1, 8'd11, 1'b1},   // R3 one above limit
        '{1'b0, 1'b0, 8'd11, 1'b1},   // R2 active low
        '{1'b0, 1'b0, 8'd3,  1'b0},   // R3 glitch
        '{1'b1, 1'b1, 8'd11, 1'b1},   // R2 second pin, active high
        '{1'b1, 1'b0, 8'd10, 1'b0},   // R3 second pin at limit
        '{1'b1, 1'b0, 8'd40, 1'b1},   // R4 long pulse, single event
        '{1'b1, 1'b1, 8'd1,  1'b0}    // R3 single cycle
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_input_mode = 2'b11;
    logic [1:0] pin_pol = 2'b11;
    logic [1:0] cap_en = 2'b11;
    logic       tmr_clr_en = 1'b0;
    logic       tmr_irq_en = 1'b0;
    logic       tmr_match = 1'b0;
    logic [1:0] sw_clr_cap = 2'b00;
    logic       sw_clr_tmr = 1'b0;
    logic [1:0] cap_sts;
    logic       tmr_sts;
    logic [1:0] cap_strobe;
    logic       irq;

    int total = 0;
    int bad   = 0;
    int sc [2] = '{0, 0};
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_ts_event_irq u_gpio_ts_event_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_input_mode(pin_input_mode),
        .pin_pol(pin_pol), .cap_en(cap_en), .tmr_clr_en(tmr_clr_en),
        .tmr_irq_en(tmr_irq_en), .tmr_match(tmr_match), .sw_clr_cap(sw_clr_cap),
        .sw_clr_tmr(sw_clr_tmr), .cap_sts(cap_sts), .tmr_sts(tmr_sts),
        .cap_strobe(cap_strobe), .irq(irq)
    );

    // Strobe counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (cap_strobe[0]) sc[0]++;
        if (cap_strobe[1]) sc[1]++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_caps();
        sw_clr_cap = 2'b11;
        cyc(1);
        sw_clr_cap = 2'b00;
        cyc(2);
    endtask

    // Drives pin p active and returns at the falling edge where its strobe shows.
    task automatic wait_strobe(input int p);
        pin_in[p] = pin_pol[p];
        for (int k = 0; k < 40; k++) begin
            cyc(1);
            if (cap_strobe[p]) break;
        end
    endtask

    task automatic release_pin(input int p);
        pin_in[p] = ~pin_pol[p];
        cyc(4);
    endtask

    initial begin
        pin_in = ~pin_pol;
        cyc(3);
        // R1 reset state
        chk("R1 cap_sts in reset", cap_sts, 0);
        chk("R1 tmr_sts in reset", tmr_sts, 0);
        chk("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 strobe after reset", cap_strobe, 0);
        cyc(4);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            int p;
            int base;
            p = VECS[v].pin;
            pin_pol[p] = VECS[v].pol;
            pin_in[p]  = ~VECS[v].pol;
            cyc(6);
            clear_caps();
            base = sc[p];
            pin_in[p] = VECS[v].pol;
            cyc(int'(VECS[v].width));
            pin_in[p] = ~VECS[v].pol;
            cyc(MIN_CYC + 8);
            chk("R2 R3 R4 strobe count", sc[p] - base, int'(VECS[v].expect_evt));
            chk("R6 capture status", cap_sts[p], int'(VECS[v].expect_evt));
            chk("R10 irq follows status", irq, int'(VECS[v].expect_evt));
            clear_caps();
        end

        // R3 strobe latency
        pin_pol = 2'b11;
        pin_in  = 2'b00;
        cyc(6);
        clear_caps();
        begin
            int lat;
            lat = -1;
            pin_in[0] = 1'b1;
            for (int k = 1; k <= 20; k++) begin
                cyc(1);
                if (cap_strobe[0] && lat < 0) lat = k;
            end
            chk("R3 strobe latency", lat, MIN_CYC + 3);
        end
        release_pin(0);
        clear_caps();

        // R5 pin not in input mode
        begin
            int base;
            pin_input_mode[1] = 1'b0;
            base = sc[1];
            pin_in[1] = 1'b1;
            cyc(30);
            pin_in[1] = 1'b0;
            cyc(4);
            chk("R5 no strobe when not input", sc[1] - base, 0);
            chk("R5 status untouched", cap_sts[1], 0);
            pin_input_mode[1] = 1'b1;
            cyc(4);
        end

        // R6 set wins over software clear in the same cycle
        wait_strobe(0);
        sw_clr_cap[0] = 1'b1;
        cyc(1);
        sw_clr_cap[0] = 1'b0;
        chk("R6 set beats clear", cap_sts[0], 1);
        release_pin(0);
        sw_clr_cap[0] = 1'b1;
        cyc(1);
        sw_clr_cap[0] = 1'b0;
        chk("R6 write-one-to-clear", cap_sts[0], 0);
        cyc(2);

        // R10 enable gating: status set but masked
        cap_en = 2'b00;
        wait_strobe(1);
        release_pin(1);
        chk("R10 masked status", cap_sts[1], 1);
        chk("R10 irq masked", irq, 0);
        cap_en = 2'b10;
        cyc(1);
        chk("R10 irq after enable", irq, 1);
        clear_caps();
        chk("R10 irq drops after clear", irq, 0);

        // R7 timer set
        tmr_match = 1'b1;
        cyc(1);
        tmr_match = 1'b0;
        chk("R7 timer set", tmr_sts, 1);

        // R8 gpio clear disabled
        tmr_clr_en = 1'b0;
        wait_strobe(1);
        cyc(1);
        chk("R8 no clear when disabled", tmr_sts, 1);
        release_pin(1);

        // R8 gpio clear enabled
        tmr_clr_en = 1'b1;
        wait_strobe(0);
        cyc(1);
        chk("R8 pin event clears timer", tmr_sts, 0);
        release_pin(0);

        // R9 timer set beats gpio clear
        tmr_match = 1'b1;
        cyc(1);
        tmr_match = 1'b0;
        wait_strobe(1);
        tmr_match = 1'b1;
        cyc(1);
        tmr_match = 1'b0;
        chk("R9 set beats gpio clear", tmr_sts, 1);
        release_pin(1);
        clear_caps();

        // R10 timer contributes to irq only when enabled
        chk("R10 timer masked", irq, 0);
        tmr_irq_en = 1'b1;
        cyc(1);
        chk("R10 timer irq", irq, 1);

        // R7 software clear of timer
        sw_clr_tmr = 1'b1;
        cyc(1);
        sw_clr_tmr = 1'b0;
        chk("R7 timer software clear", tmr_sts, 0);
        cyc(1);
        chk("R10 irq low after timer clear", irq, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule